// File: doc/BRIEF.md
# Slow Tick Source Selector

This block produces the low-rate timebase tick that drives a real-time clock. It picks one of two tick sources: an external crystal tick, or an internal RC-oscillator tick. The internal tick first passes a fixed pre-divider and then a programmable divide-by-(N+1) stage. All ticks are single-cycle enables in the system clock domain, so no derived clocks are created. The selected tick comes out one cycle after the source tick that caused it.

A small register bus carries a write strobe, a byte address, write data and combinational read data. Software uses it to set up the source, the divider, an output-gate bit and a supervision window. The control register is guarded by a key: a write changes it only when the upper halfword of the write data carries the key value. When the external source is selected and supervision is not bypassed, the block watches for crystal ticks. If a whole window passes with none, it falls back to the internal path and raises a sticky status bit. An accepted control write clears that bit.

Top module: `slow_tick_sel`

## Requirements
- R1: A write to address 0x00 updates the control register only when wdata[31:16] equals 16'h16AA. Any other upper halfword leaves the register unchanged.
- R2: A read of address 0x00 returns the source select at bit 0, the crystal enable at bit 4 and the fallback bypass at bit 15. All other bits, including the key field 31:16, read as zero.
- R3: While the external source is in use (control bit 0 = 1, no fallback), tick_o pulses once for every cycle that ext_tick_i is high, one cycle later, with no division.
- R4: While the internal source is in use, tick_o gives one pulse per PRE_DIV*(N+1) int_tick_i pulses, where PRE_DIV defaults to 32 and N is bits 4:0 at address 0x08. A write to 0x08 restarts both divider stages, and ext_tick_i has no effect on tick_o.
- R5: xtal_en_o follows control bit 4.
- R6: Bit 0 at address 0x60 drives clkout_en_o and reads back from that address.
- R7: Supervision is armed when control bit 0 = 1 and bit 15 = 0, with window W (address 0x0C) not zero. After W consecutive cycles without an ext_tick_i pulse, fallback_o and status bit 0 at address 0x04 go high. A crystal tick restarts the window. In fallback the internal path drives tick_o and ext_tick_i is ignored.
- R8: With control bit 15 = 1, or with W = 0, fallback never occurs.
- R9: An accepted control write clears fallback and restarts the window. If it lands in the cycle the window would expire, the clear wins.
- R10: After reset all registers, tick_o, clkout_en_o, xtal_en_o and fallback_o are zero, and the internal source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| int_tick_i | input | 1 | Internal RC oscillator tick |
| ext_tick_i | input | 1 | External crystal tick |
| tick_o | output | 1 | Selected slow tick enable |
| clkout_en_o | output | 1 | Slow clock output gate enable |
| xtal_en_o | output | 1 | External oscillator enable |
| fallback_o | output | 1 | Fallback to internal source active |

## Verification
Two events can fall in the same cycle: an accepted control write, and the expiry of the supervision window. The bench arms supervision with a keyed write. It then times a second keyed write so that its clock edge is exactly the W-th cycle without a crystal tick. It requires fallback_o to stay low just after that edge and to rise only after a further full window. The rule that a crystal tick restarts the window is tested the same way, by placing a tick mid-window and checking when expiry occurs.

// File: rtl/slow_tick_pkg.sv
package slow_tick_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [15:0] CTRL_KEY = 16'h16AA;

  localparam logic [AW-1:0] ADDR_CTRL  = 8'h00;
  localparam logic [AW-1:0] ADDR_STAT  = 8'h04;
  localparam logic [AW-1:0] ADDR_PRESC = 8'h08;
  localparam logic [AW-1:0] ADDR_WIN   = 8'h0C;
  localparam logic [AW-1:0] ADDR_GATE  = 8'h60;

  localparam int unsigned SRC_BIT = 0;
  localparam int unsigned XEN_BIT = 4;
  localparam int unsigned BYP_BIT = 15;

  typedef struct packed {
    logic bypass;
    logic xtal_en;
    logic src_ext;
  } ctrl_t;
endpackage

// File: rtl/slow_tick_regs.sv
module slow_tick_regs
  import slow_tick_pkg::*;
#(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             fall_i,
  output ctrl_t            ctrl_o,
  output logic [DIV_W-1:0] presc_o,
  output logic [WIN_W-1:0] window_o,
  output logic             gate_o,
  output logic             ctrl_wr_o,
  output logic             presc_wr_o,
  output logic [DW-1:0]    rdata_o
);
  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] presc_q;
  logic [WIN_W-1:0] window_q;
  logic             gate_q;

  assign ctrl_wr_o  = wr_en_i && addr_i == ADDR_CTRL && wdata_i[31:16] == CTRL_KEY;
  assign presc_wr_o = wr_en_i && addr_i == ADDR_PRESC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      presc_q  <= '0;
      window_q <= '0;
      gate_q   <= 1'b0;
    end else begin
      if (ctrl_wr_o) begin
        ctrl_q.src_ext <= wdata_i[SRC_BIT];
        ctrl_q.xtal_en <= wdata_i[XEN_BIT];
        ctrl_q.bypass  <= wdata_i[BYP_BIT];
      end
      if (presc_wr_o) presc_q <= wdata_i[DIV_W-1:0];
      if (wr_en_i && addr_i == ADDR_WIN) window_q <= wdata_i[WIN_W-1:0];
      if (wr_en_i && addr_i == ADDR_GATE) gate_q <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[SRC_BIT] = ctrl_q.src_ext;
        rdata_o[XEN_BIT] = ctrl_q.xtal_en;
        rdata_o[BYP_BIT] = ctrl_q.bypass;
      end
      ADDR_STAT:  rdata_o[0] = fall_i;
      ADDR_PRESC: rdata_o[DIV_W-1:0] = presc_q;
      ADDR_WIN:   rdata_o[WIN_W-1:0] = window_q;
      ADDR_GATE:  rdata_o[0] = gate_q;
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign presc_o  = presc_q;
  assign window_o = window_q;
  assign gate_o   = gate_q;
endmodule

// File: rtl/slow_tick_div.sv
module slow_tick_div #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = cnt_q >= limit_i;
  assign tick_o = tick_i & wrap & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/slow_tick_fallback.sv
module slow_tick_fallback #(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             clear_i,
  input  logic             ext_tick_i,
  input  logic [WIN_W-1:0] window_i,
  output logic             fall_o
);
  logic [WIN_W-1:0] cnt_q;
  logic             fall_q;
  logic             expire;

  assign expire = window_i != '0 && cnt_q == window_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fall_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      fall_q <= 1'b0;
    end else if (!arm_i || ext_tick_i) begin
      cnt_q <= '0;
    end else if (!fall_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (expire) fall_q <= 1'b1;
    end
  end

  assign fall_o = fall_q;
endmodule

// File: rtl/slow_tick_sel.sv
module slow_tick_sel
  import slow_tick_pkg::*;
#(
  parameter int unsigned PRE_DIV = 32,
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned WIN_W   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          int_tick_i,
  input  logic          ext_tick_i,
  output logic          tick_o,
  output logic          clkout_en_o,
  output logic          xtal_en_o,
  output logic          fallback_o
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  ctrl_t            ctrl;
  logic [DIV_W-1:0] presc_n;
  logic [WIN_W-1:0] window;
  logic             gate_en, ctrl_wr, presc_wr, fall;
  logic             pre_tick, int_div_tick, sel_ext, tick_q;

  slow_tick_regs #(.DIV_W(DIV_W), .WIN_W(WIN_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .fall_i     (fall),
    .ctrl_o     (ctrl),
    .presc_o    (presc_n),
    .window_o   (window),
    .gate_o     (gate_en),
    .ctrl_wr_o  (ctrl_wr),
    .presc_wr_o (presc_wr),
    .rdata_o
  );

  generate
    if (PRE_DIV > 1) begin : g_pre
      slow_tick_div #(.CW(PRE_W)) i_pre (
        .clk_i, .rst_ni,
        .restart_i (presc_wr),
        .tick_i    (int_tick_i),
        .limit_i   (PRE_W'(PRE_DIV - 1)),
        .tick_o    (pre_tick)
      );
    end else begin : g_nopre
      assign pre_tick = int_tick_i & ~presc_wr;
    end
  endgenerate

  slow_tick_div #(.CW(DIV_W)) i_div (
    .clk_i, .rst_ni,
    .restart_i (presc_wr),
    .tick_i    (pre_tick),
    .limit_i   (presc_n),
    .tick_o    (int_div_tick)
  );

  slow_tick_fallback #(.WIN_W(WIN_W)) i_fb (
    .clk_i, .rst_ni,
    .arm_i      (ctrl.src_ext & ~ctrl.bypass),
    .clear_i    (ctrl_wr),
    .ext_tick_i,
    .window_i   (window),
    .fall_o     (fall)
  );

  assign sel_ext = ctrl.src_ext & ~fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= sel_ext ? ext_tick_i : int_div_tick;
  end

  assign tick_o      = tick_q;
  assign clkout_en_o = gate_en;
  assign xtal_en_o   = ctrl.xtal_en;
  assign fallback_o  = fall;
endmodule

// File: rtl/slow_tick_sel_chk.sv
module slow_tick_sel_chk
  import slow_tick_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          int_tick_i,
  input logic          ext_tick_i,
  input logic          tick_o,
  input logic          fallback_o,
  input logic          sel_ext_i,
  input logic          bypass_i,
  input logic [2:0]    ctrl_bits_i
);
  logic ctrl_hit, key_ok;
  assign ctrl_hit = wr_en_i && addr_i == ADDR_CTRL;
  assign key_ok   = ctrl_hit && wdata_i[31:16] == CTRL_KEY;

  a_r1_bad_key_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit && !key_ok |=> $stable(ctrl_bits_i));

  a_r3_ext_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ext_i && ext_tick_i |=> tick_o);

  a_r4_int_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ext_i && !int_tick_i |=> !tick_o);

  a_r7_fallback_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o && !key_ok |=> fallback_o);

  a_r8_bypass_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i && !fallback_o |=> !fallback_o);

  a_r9_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ok |=> !fallback_o);
endmodule

bind slow_tick_sel slow_tick_sel_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .int_tick_i  (int_tick_i),
  .ext_tick_i  (ext_tick_i),
  .tick_o      (tick_o),
  .fallback_o  (fallback_o),
  .sel_ext_i   (sel_ext),
  .bypass_i    (ctrl.bypass),
  .ctrl_bits_i (ctrl)
);

// File: tb/test_slow_tick_sel.sv
`timescale 1ns/1ps
module test_slow_tick_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        int_tick_i = 1'b0;
  logic        ext_tick_i = 1'b0;
  logic        tick_o, clkout_en_o, xtal_en_o, fallback_o;

  int errors = 0;
  int checks = 0;
  int tick_cnt = 0;
  bit done = 1'b0;
  localparam int W = 8;

  always #5 clk_i = ~clk_i;

  slow_tick_sel i_slow_tick_sel (.*);

  always @(negedge clk_i) if (tick_o) tick_cnt++;

  typedef struct packed {
    logic        src;
    logic [4:0]  n;
    logic [15:0] nint;
    logic [7:0]  next;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 5'd0,  16'd100,  8'd0, 16'd3},
    '{1'b0, 5'd1,  16'd200,  8'd5, 16'd3},
    '{1'b0, 5'd31, 16'd1024, 8'd0, 16'd1},
    '{1'b0, 5'd31, 16'd1023, 8'd0, 16'd0},
    '{1'b1, 5'd0,  16'd100,  8'd7, 16'd7},
    '{1'b1, 5'd3,  16'd0,    8'd1, 16'd1},
    '{1'b0, 5'd2,  16'd96,   8'd0, 16'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse_int(input int k);
    if (k > 0) begin
      @(negedge clk_i); int_tick_i = 1'b1;
      repeat (k) @(negedge clk_i);
      int_tick_i = 1'b0;
    end
  endtask

  task automatic pulse_ext(input int k);
    if (k > 0) begin
      @(negedge clk_i); ext_tick_i = 1'b1;
      repeat (k) @(negedge clk_i);
      ext_tick_i = 1'b0;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10 reset state
    rd(8'h00, d); check("R10 ctrl", d, 0);
    rd(8'h08, d); check("R10 presc", d, 0);
    rd(8'h04, d); check("R10 status", d, 0);
    rd(8'h60, d); check("R10 gate", d, 0);
    check("R10 outputs", {tick_o, clkout_en_o, xtal_en_o, fallback_o}, 0);

    // R1 bad key ignored
    wr(8'h00, 32'h16AB_FFFF);
    rd(8'h00, d); check("R1 bad key", d, 0);
    // R1/R2 good key, masked readback
    wr(8'h00, 32'h16AA_FFFF);
    rd(8'h00, d); check("R2 readback", d, 32'h0000_8011);
    check("R5 xtal_en", xtal_en_o, 1);
    wr(8'h00, 32'h16AA_0000);
    check("R5 xtal_en off", xtal_en_o, 0);

    // R6 gate
    wr(8'h60, 32'h1);
    check("R6 clkout_en", clkout_en_o, 1);
    rd(8'h60, d); check("R6 readback", d, 1);

    // R3/R4 vector table, bypass on
    foreach (VECS[i]) begin
      wr(8'h00, {16'h16AA, 16'h8000 | 16'(VECS[i].src)});
      wr(8'h08, 32'(VECS[i].n));
      tick_cnt = 0;
      pulse_int(int'(VECS[i].nint));
      pulse_ext(int'(VECS[i].next));
      repeat (3) @(negedge clk_i);
      check(VECS[i].src ? "R3 ext ticks" : "R4 int ticks", tick_cnt, 32'(VECS[i].exp));
    end

    // R7 fallback after W silent cycles; crystal tick restarts window
    wr(8'h0C, W);
    wr(8'h08, 0);
    wr(8'h00, 32'h16AA_0011);
    repeat (5) @(posedge clk_i);
    @(negedge clk_i); ext_tick_i = 1'b1;
    @(negedge clk_i); ext_tick_i = 1'b0;
    repeat (W - 1) @(posedge clk_i);
    @(negedge clk_i); check("R7 before expiry", fallback_o, 0);
    @(posedge clk_i);
    @(negedge clk_i); check("R7 at expiry", fallback_o, 1);
    rd(8'h04, d); check("R7 status", d, 1);
    tick_cnt = 0;
    pulse_ext(3);
    pulse_int(64);
    repeat (3) @(negedge clk_i);
    check("R7 internal drives tick", tick_cnt, 2);

    // R9 clear on write, and write coinciding with expiry
    wr(8'h00, 32'h16AA_0011);
    check("R9 clear", fallback_o, 0);
    repeat (W - 1) @(posedge clk_i);
    wr(8'h00, 32'h16AA_0011);
    check("R9 clear wins", fallback_o, 0);
    repeat (W - 1) @(posedge clk_i);
    @(negedge clk_i); check("R9 window restarted", fallback_o, 0);
    @(posedge clk_i);
    @(negedge clk_i); check("R9 later expiry", fallback_o, 1);

    // R8 bypass, then zero window
    wr(8'h00, 32'h16AA_8011);
    repeat (3 * W) @(negedge clk_i);
    check("R8 bypass", fallback_o, 0);
    wr(8'h0C, 0);
    wr(8'h00, 32'h16AA_0011);
    repeat (3 * W) @(negedge clk_i);
    check("R8 zero window", fallback_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule